// File: doc/BRIEF.md
# Console UART Register Front End

This block is the byte-wide register window of a simple console UART. A host bus reaches eight consecutive byte offsets through one access port. One single-cycle access is made per request. On the device side, a receive stream presents a byte with a valid flag, and a transmit stream emits a byte with a one-cycle strobe. The block has no serial bit timing, no FIFO and no modem lines. It keeps only the programming model: the data path, interrupt enable and identification, line control and status, the modem-control loopback quirk, and the divisor latch. The divisor latch is stored but drives nothing.

Two interrupt sources are tracked. A receive interrupt is pending while a byte waits and receive interrupts are enabled. A transmit interrupt is armed by software. After a programmable delay it becomes pending, and a read of the identification register or a new transmit byte withdraws it. One interrupt line reports whether either source is pending. The block is used as a polled or interrupt-driven console port whose software model only needs these registers.

Top module: `uart_regfile`

## Requirements
- R1: After reset, interrupt enable, line control, modem control and both divisor bytes read 0x00, `irq` is low and offset 2 reads 0x01.
- R2: A read of offset 0 with line-control bit 7 clear returns `rx_data` and pulses `rx_pop` in that cycle when `rx_valid` is high. With `rx_valid` low it returns 0x00 and does not pulse `rx_pop`.
- R3: A write of offset 0 with line-control bit 7 clear sets `tx_valid` with `tx_data` equal to the written byte in the following cycle. It clears a pending transmit interrupt. When interrupt-enable bit 1 is set, it also arms a new one.
- R4: Offset 1 with line-control bit 7 clear is the readable and writable interrupt-enable register. Writing it with bit 1 set arms a transmit interrupt. An armed transmit interrupt becomes pending exactly TX_DELAY clock edges after the arming write.
- R5: With line-control bit 7 set, offsets 0 and 1 read and write two divisor bytes. They make no transmit strobe and no receive pop, and they leave the interrupt-enable register unchanged.
- R6: Offset 2 reads 0x04 when a receive interrupt is pending (`rx_valid` high and interrupt-enable bit 0 set). Otherwise it reads 0x02 when a transmit interrupt is pending, and otherwise 0x01.
- R7: Every read of offset 2 clears the pending transmit interrupt.
- R8: Offset 3 is a line-control register that reads back every bit written.
- R9: Offset 4 holds the modem-control register. Offset 5 reads 0x60 with bit 0 equal to `rx_valid` (data ready at bit 0, holding empty at bit 5, transmitter empty at bit 6).
- R10: Writing exactly 0x1A to offset 4 (loopback bit 4 plus 0x0A) loads the modem-control register with 0x9A. Any other value written there leaves it unchanged.
- R11: Offsets 6 and 7 always read 0x00. Writes to offsets 2 and 7 change no register, no output and no pending interrupt.
- R12: `irq` is high exactly while a receive or a transmit interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the request cycle |
| rx_valid | input | 1 | A received byte is available |
| rx_data | input | 8 | Received byte |
| rx_pop | output | 1 | Received byte consumed this cycle |
| tx_valid | output | 1 | Transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The data path is tried with receive bytes present and absent, and with the divisor-latch bit both clear and set. This separates the data register from the divisor storage and catches a pop or strobe that leaks through the wrong mode. The interrupt logic is tried with only a transmit source, with only a receive source, and with both at once. These show the delay count, the priority order, and the two ways a transmit interrupt is withdrawn. The modem-control writes use the exact loopback value, a near miss without the loopback bit, and an unrelated value, to show that only the exact pattern loads it.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  typedef logic [7:0] byte_t;
  typedef logic [2:0] ofs_t;

  localparam ofs_t OFS_DATA = 3'd0;
  localparam ofs_t OFS_IEN  = 3'd1;
  localparam ofs_t OFS_IID  = 3'd2;
  localparam ofs_t OFS_LCTL = 3'd3;
  localparam ofs_t OFS_MCTL = 3'd4;
  localparam ofs_t OFS_LSTA = 3'd5;
  localparam ofs_t OFS_MSTA = 3'd6;
  localparam ofs_t OFS_SCR  = 3'd7;

  localparam byte_t IID_NONE = 8'h01;
  localparam byte_t IID_TX   = 8'h02;
  localparam byte_t IID_RX   = 8'h04;

  localparam int IEN_RX_BIT  = 0;
  localparam int IEN_TX_BIT  = 1;
  localparam int LCTL_DL_BIT = 7;

  localparam byte_t LSTA_FIXED = 8'h60;
  localparam byte_t MCTL_MAGIC = 8'h1A;
  localparam byte_t MCTL_LOAD  = 8'h9A;
endpackage

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ofs_t  wr_addr,
  input  byte_t wr_data,
  output byte_t ien,
  output byte_t lctl,
  output byte_t mctl,
  output byte_t div_lo,
  output byte_t div_hi
);
  logic  dl_sel;
  logic  ien_en, lctl_en, mctl_en, dlo_en, dhi_en;
  byte_t ien_q, lctl_q, mctl_q, dlo_q, dhi_q;

  assign dl_sel = lctl_q[LCTL_DL_BIT];

  always_comb begin
    ien_en  = wr_en && (wr_addr == OFS_IEN)  && !dl_sel;
    dhi_en  = wr_en && (wr_addr == OFS_IEN)  &&  dl_sel;
    dlo_en  = wr_en && (wr_addr == OFS_DATA) &&  dl_sel;
    lctl_en = wr_en && (wr_addr == OFS_LCTL);
    mctl_en = wr_en && (wr_addr == OFS_MCTL) && (wr_data == MCTL_MAGIC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
    end else begin
      if (ien_en)  ien_q  <= wr_data;
      if (lctl_en) lctl_q <= wr_data;
      if (mctl_en) mctl_q <= MCTL_LOAD;
      if (dlo_en)  dlo_q  <= wr_data;
      if (dhi_en)  dhi_q  <= wr_data;
    end
  end

  assign ien    = ien_q;
  assign lctl   = lctl_q;
  assign mctl   = mctl_q;
  assign div_lo = dlo_q;
  assign div_hi = dhi_q;
endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int TX_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  localparam int CW = $clog2(TX_DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(TX_DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm || (cnt_q != '0);
    if (arm) cnt_d = LOAD;
    else     cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == ONE);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_avail,
  input  logic  rx_ien,
  input  logic  tx_expire,
  input  logic  tx_clear,
  output logic  tx_pend,
  output byte_t iid,
  output logic  irq
);
  logic tx_pend_q, tx_pend_d, rx_pend;

  always_comb begin
    tx_pend_d = tx_expire || (tx_pend_q && !tx_clear);
    rx_pend   = rx_avail && rx_ien;
    if (rx_pend)        iid = IID_RX;
    else if (tx_pend_q) iid = IID_TX;
    else                iid = IID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_pend_q <= 1'b0;
    else        tx_pend_q <= tx_pend_d;
  end

  assign tx_pend = tx_pend_q;
  assign irq     = rx_pend || tx_pend_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int TX_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_pop,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       irq
);
  byte_t ien_w, lctl_w, mctl_w, dlo_w, dhi_w, iid_w;
  logic  wr_en, rd_en, dl_sel;
  logic  data_wr, tx_arm, tx_clr, tx_expire_w, tx_pend_w;
  logic  txv_q, txv_d;
  byte_t txd_q;

  assign wr_en  = bus_sel && bus_we;
  assign rd_en  = bus_sel && !bus_we;
  assign dl_sel = lctl_w[LCTL_DL_BIT];

  always_comb begin
    data_wr = wr_en && (bus_addr == OFS_DATA) && !dl_sel;
    tx_arm  = (data_wr && ien_w[IEN_TX_BIT]) ||
              (wr_en && (bus_addr == OFS_IEN) && !dl_sel && bus_wdata[IEN_TX_BIT]);
    tx_clr  = data_wr || (rd_en && (bus_addr == OFS_IID));
    txv_d   = data_wr;
  end

  uart_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .ien     (ien_w),
    .lctl    (lctl_w),
    .mctl    (mctl_w),
    .div_lo  (dlo_w),
    .div_hi  (dhi_w)
  );

  uart_tx_timer #(.TX_DELAY(TX_DELAY)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (tx_arm),
    .expire (tx_expire_w)
  );

  uart_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_avail  (rx_valid),
    .rx_ien    (ien_w[IEN_RX_BIT]),
    .tx_expire (tx_expire_w),
    .tx_clear  (tx_clr),
    .tx_pend   (tx_pend_w),
    .iid       (iid_w),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txv_q <= txv_d;
      if (data_wr) txd_q <= bus_wdata;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
  assign rx_pop   = rd_en && (bus_addr == OFS_DATA) && !dl_sel && rx_valid;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = dl_sel ? dlo_w : (rx_valid ? rx_data : 8'h00);
        OFS_IEN:  bus_rdata = dl_sel ? dhi_w : ien_w;
        OFS_IID:  bus_rdata = iid_w;
        OFS_LCTL: bus_rdata = lctl_w;
        OFS_MCTL: bus_rdata = mctl_w;
        OFS_LSTA: bus_rdata = LSTA_FIXED | {7'd0, rx_valid};
        OFS_MSTA: bus_rdata = 8'h00;
        OFS_SCR:  bus_rdata = 8'h00;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rx_valid,
  input logic       rx_pop,
  input logic       tx_valid,
  input logic       irq,
  input logic [7:0] ien,
  input logic [7:0] lctl,
  input logic [7:0] mctl,
  input logic       tx_pend,
  input logic       tx_expire
);
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 3'd2 && rx_valid && ien[0]) |-> bus_rdata == 8'h04); // R6

  AST_IID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 3'd2 && !irq) |-> bus_rdata == 8'h01); // R12

  AST_IID_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 3'd2 && !tx_expire) |=> !tx_pend); // R7

  AST_LSTA_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_valid)); // R9

  AST_ZERO_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[2:1] == 2'b11) |-> bus_rdata == 8'h00); // R11

  AST_MCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd4 && bus_wdata != 8'h1A) |=> $stable(mctl)); // R10

  AST_TX_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(bus_sel && bus_we && bus_addr == 3'd0 && !lctl[7])); // R3

  AST_DL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    lctl[7] |-> !rx_pop); // R5

  AST_DL_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd1 && lctl[7]) |=> $stable(ien)); // R5
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .rx_pop    (rx_pop),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .ien       (ien_w),
  .lctl      (lctl_w),
  .mctl      (mctl_w),
  .tx_pend   (tx_pend_w),
  .tx_expire (tx_expire_w)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  localparam int DLY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_pop, tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_regfile #(.TX_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  // Behavioural reference for interrupt and transmit outputs
  int m_ien, m_lctl, m_txp, m_cnt, m_txv, m_txd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ien = 0; m_lctl = 0; m_txp = 0; m_cnt = 0; m_txv = 0; m_txd = 0;
    end else begin
      automatic bit dl = m_lctl[7];
      automatic bit dwr = bus_sel && bus_we && bus_addr == 0 && !dl;
      automatic bit iwr = bus_sel && bus_we && bus_addr == 1 && !dl;
      automatic bit iidrd = bus_sel && !bus_we && bus_addr == 2;
      automatic bit arm = (dwr && m_ien[1]) || (iwr && bus_wdata[1]);
      automatic bit fire = (m_cnt == 1);
      if (fire) m_txp = 1;
      else if (dwr || iidrd) m_txp = 0;
      if (arm) m_cnt = DLY;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_txv = dwr;
      if (dwr) m_txd = bus_wdata;
      if (iwr) m_ien = bus_wdata;
      if (bus_sel && bus_we && bus_addr == 3) m_lctl = bus_wdata;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      automatic int eirq = ((rx_valid && m_ien[0]) || m_txp) ? 1 : 0;
      checks++;
      if (irq !== eirq[0]) begin
        errors++;
        $display("FAIL R12 irq actual=%0b expected=%0b at %0t", irq, eirq[0], $time);
      end
      checks++;
      if (tx_valid !== m_txv[0] || (m_txv != 0 && tx_data !== m_txd[7:0])) begin
        errors++;
        $display("FAIL R3 tx actual=%0b/%02h expected=%0b/%02h at %0t",
                 tx_valid, tx_data, m_txv[0], m_txd[7:0], $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input logic exp_pop, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #5;
    chk(tag, bus_rdata, exp);
    chk({tag, " pop"}, {7'd0, rx_pop}, {7'd0, exp_pop});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd2, 8'h01, 1'b0, "R1 iid");
    rd(3'd1, 8'h00, 1'b0, "R1 ien");
    rd(3'd3, 8'h00, 1'b0, "R1 lctl");
    rd(3'd4, 8'h00, 1'b0, "R1 mctl");

    // R2 receive path
    rd(3'd0, 8'h00, 1'b0, "R2 empty");
    @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'h5A; end
    rd(3'd0, 8'h5A, 1'b1, "R2 byte");
    rd(3'd5, 8'h61, 1'b0, "R9 lsta ready");
    @(negedge clk) rx_valid = 1'b0;
    rd(3'd5, 8'h60, 1'b0, "R9 lsta empty");

    // R8 / R5 divisor access
    wr(3'd3, 8'h83);
    rd(3'd3, 8'h83, 1'b0, "R8 lctl");
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'hC3; end
    rd(3'd0, 8'h12, 1'b0, "R5 div lo");
    rd(3'd1, 8'h34, 1'b0, "R5 div hi");
    @(negedge clk) rx_valid = 1'b0;
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, 1'b0, "R5 ien untouched");
    rd(3'd3, 8'h03, 1'b0, "R8 lctl low");

    // R4 / R6 / R7 transmit interrupt via enable write
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, 1'b0, "R4 ien");
    idle(DLY);
    chk("R4 irq after delay", {7'd0, irq}, 8'h01);
    rd(3'd2, 8'h02, 1'b0, "R6 tx code");
    rd(3'd2, 8'h01, 1'b0, "R7 cleared");
    chk("R7 irq low", {7'd0, irq}, 8'h00);

    // R3 data write clears and re-arms
    wr(3'd0, 8'h41);
    idle(DLY);
    chk("R3 rearmed irq", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h42);
    chk("R3 clear irq", {7'd0, irq}, 8'h00);
    idle(DLY);
    chk("R3 irq again", {7'd0, irq}, 8'h01);

    // R6 priority with both pending
    wr(3'd1, 8'h01);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'h77; end
    rd(3'd2, 8'h04, 1'b0, "R6 rx first");
    @(negedge clk) rx_valid = 1'b0;
    idle(1);
    chk("R12 idle irq", {7'd0, irq}, 8'h00);
    rd(3'd2, 8'h01, 1'b0, "R7 tx gone");

    // R10 modem control
    wr(3'd4, 8'h0A);
    rd(3'd4, 8'h00, 1'b0, "R10 near miss");
    wr(3'd4, 8'h1A);
    rd(3'd4, 8'h9A, 1'b0, "R10 magic");
    wr(3'd4, 8'h05);
    rd(3'd4, 8'h9A, 1'b0, "R10 hold");

    // R11 zero regs and ignored writes
    wr(3'd7, 8'hFF);
    wr(3'd2, 8'hFF);
    rd(3'd6, 8'h00, 1'b0, "R11 msta");
    rd(3'd7, 8'h00, 1'b0, "R11 scr");
    rd(3'd2, 8'h01, 1'b0, "R11 iid after writes");
    rd(3'd1, 8'h01, 1'b0, "R11 ien after writes");
    rd(3'd3, 8'h03, 1'b0, "R11 lctl after writes");
    idle(DLY + 1);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    report();
  end
endmodule